// File: doc/BRIEF.md
# Game-Controller Port Register Block

This block sits between a processor-style register bus and four digital game-controller ports. It lets software read the switch state of all four sticks and their fire buttons. It also returns the positions of two analog paddle pairs and a light gun, which arrive from external converters as parallel buses. Every pin-side input passes through a two-flop synchronizer before software can read it. The paddle and gun buses are captured into a register stage every cycle.

The direction lines of sticks 0 and 2 can also be driven as outputs. A bus write to the direction register loads the written bits into an output register and switches on the drive for those eight pins. The drive stays on until software reads the direction register, and that read switches it off. Sticks 1 and 3 are never driven. Read data is registered and appears on the cycle after the read strobe.

Top module: `joyport_regs`

## Requirements
- R1: After reset, `dir_oe` and `dir_out` are all zero and `bus_rdata` is zero.
- R2: A read at address 1 returns the synchronized direction pins. Nibble k (bits 4k+3..4k) belongs to stick k, with bit 3 of a nibble = Up, bit 2 = Down, bit 1 = Left and bit 0 = Right. The read value reflects a pin that has been stable for at least three clock cycles.
- R3: A write at address 1 sets `dir_out` to the write data masked with 16'h0F0F, so only sticks 0 and 2 are written. From the next cycle, `dir_oe` equals 16'h0F0F. Bits of sticks 1 and 3 in `dir_oe` and `dir_out` are always zero.
- R4: A read at address 1 sets `dir_oe` to zero on the next cycle. Reads at any other address leave `dir_oe` unchanged.
- R5: Between a direction write and the next direction read, `dir_oe` stays on. Writes to other addresses change neither `dir_out` nor `dir_oe`. After the drive is released, `dir_out` keeps the last written value.
- R6: A read at address 0 returns the fire buttons in bits 3..0 as {stick 3, stick 1, stick 2, stick 0}, from bit 3 down to bit 0. Bits 15..4 read as zero.
- R7: Paddle trigger inputs 0 and 1 are ORed into bits 1 and 2 of the direction read value, respectively.
- R8: Addresses 2, 3, 4 and 5 return paddle positions 0 X, 0 Y, 1 X and 1 Y in bits 7..0, with the upper bits zero. Position n is taken from `pad_pos[8n+7:8n]`.
- R9: Addresses 6 and 7 return the light-gun X and Y positions in bits 9..0, with the upper bits zero.
- R10: `bus_rdata` changes only on the cycle after a read strobe and holds its value otherwise.
- R11: If a direction write and a direction read occur in the same cycle, the write wins: the drive ends up on and `dir_out` takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| dir_in | input | 16 | Direction pin levels as seen at the pads |
| dir_out | output | 16 | Direction pin output values |
| dir_oe | output | 16 | Direction pin output enables |
| fire_in | input | 4 | Fire button levels, bit k = stick k |
| trig_in | input | 2 | Paddle trigger levels |
| pad_pos | input | 32 | Four 8-bit paddle positions |
| gun_x | input | 10 | Light-gun X position |
| gun_y | input | 10 | Light-gun Y position |

## Verification
The assertions assume a one-cycle strobe protocol: `bus_rd` and `bus_wr` are single-cycle pulses, and the address is valid whenever either one is high. They also assume that the paddle and gun buses change only while no read is sampling them. The stimulus drives every strobe for exactly one cycle from the falling edge. Before any read, it holds the pins, triggers and position buses steady for three cycles, so the synchronized value that the bench model predicts is the one captured. It mixes random writes, input changes and reads at random addresses with directed cases for reset, release by read, a read of a different address, and a write and read in the same cycle.

// File: rtl/joyport_pkg.sv
package joyport_pkg;
  localparam int STICKS  = 4;
  localparam int NIB     = 4;
  localparam int DIR_W   = STICKS * NIB;
  localparam int BUS_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int PAD_W   = 8;
  localparam int PADS    = 4;
  localparam int GUN_W   = 10;
  localparam int TRIGS   = 2;
  localparam logic [STICKS-1:0] DRIVE_MASK = 4'b0101;

  typedef enum logic [ADDR_W-1:0] {
    A_FIRE  = 3'd0,
    A_DIR   = 3'd1,
    A_PAD0X = 3'd2,
    A_PAD0Y = 3'd3,
    A_PAD1X = 3'd4,
    A_PAD1Y = 3'd5,
    A_GUNX  = 3'd6,
    A_GUNY  = 3'd7
  } jp_addr_e;

  function automatic logic [DIR_W-1:0] pin_mask();
    logic [DIR_W-1:0] m;
    for (int s = 0; s < STICKS; s++) begin
      m[s*NIB +: NIB] = {NIB{DRIVE_MASK[s]}};
    end
    return m;
  endfunction
endpackage

// File: rtl/jp_sync.sv
module jp_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] st_d [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb st_d[i] = d;
      end else begin : g_next
        always_comb st_d[i] = st_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[i] <= '0;
        else        st_q[i] <= st_d[i];
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/jp_drive.sv
module jp_drive
  import joyport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             rd_dir,
  input  logic [DIR_W-1:0] wdata,
  output logic [DIR_W-1:0] dir_out,
  output logic [DIR_W-1:0] dir_oe
);
  localparam logic [DIR_W-1:0] PMASK = pin_mask();

  logic             drive_q, drive_d;
  logic [DIR_W-1:0] out_q, out_d;
  logic             out_en;

  always_comb begin
    drive_d = drive_q;
    if (wr_dir)      drive_d = 1'b1;
    else if (rd_dir) drive_d = 1'b0;
    out_en = wr_dir;
    out_d  = wdata & PMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assign dir_out = out_q;
  assign dir_oe  = drive_q ? PMASK : '0;

  // R3
  drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_oe == PMASK));
  // R4
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dir && !wr_dir) |=> (dir_oe == '0));
  // R5
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_dir && !wr_dir) |=> $stable(dir_oe));
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_out));
  // R3
  ro_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_oe & ~PMASK) == '0) && ((dir_out & ~PMASK) == '0));
endmodule

// File: rtl/jp_rdmux.sv
module jp_rdmux
  import joyport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DIR_W-1:0]      dir_val,
  input  logic [NIB-1:0]        fire_val,
  input  logic [PADS*PAD_W-1:0] pad_pos,
  input  logic [GUN_W-1:0]      gun_x,
  input  logic [GUN_W-1:0]      gun_y,
  output logic [BUS_W-1:0]      rdata
);
  logic [PADS*PAD_W-1:0] pad_q;
  logic [GUN_W-1:0]      gx_q, gy_q;
  logic [BUS_W-1:0]      rdata_q, rdata_d;
  logic [PAD_W-1:0]      pad_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
      gx_q  <= '0;
      gy_q  <= '0;
    end else begin
      pad_q <= pad_pos;
      gx_q  <= gun_x;
      gy_q  <= gun_y;
    end
  end

  always_comb begin
    pad_sel = pad_q[(addr - ADDR_W'(A_PAD0X)) * PAD_W +: PAD_W];
    rdata_d = '0;
    case (addr)
      A_FIRE:  rdata_d[NIB-1:0] = fire_val;
      A_DIR:   rdata_d[DIR_W-1:0] = dir_val;
      A_PAD0X, A_PAD0Y, A_PAD1X, A_PAD1Y:
               rdata_d[PAD_W-1:0] = pad_sel;
      A_GUNX:  rdata_d[GUN_W-1:0] = gx_q;
      A_GUNY:  rdata_d[GUN_W-1:0] = gy_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  // R6
  fire_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_FIRE) |=> (rdata[BUS_W-1:NIB] == '0));
  // R8
  pad_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr >= A_PAD0X && addr <= A_PAD1Y) |=> (rdata[BUS_W-1:PAD_W] == '0));
  // R9
  gun_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr >= A_GUNX) |=> (rdata[BUS_W-1:GUN_W] == '0));
endmodule

// File: rtl/joyport_regs.sv
module joyport_regs
  import joyport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [DIR_W-1:0]      dir_in,
  output logic [DIR_W-1:0]      dir_out,
  output logic [DIR_W-1:0]      dir_oe,
  input  logic [STICKS-1:0]     fire_in,
  input  logic [TRIGS-1:0]      trig_in,
  input  logic [PADS*PAD_W-1:0] pad_pos,
  input  logic [GUN_W-1:0]      gun_x,
  input  logic [GUN_W-1:0]      gun_y
);
  localparam int SYNC_STAGES = 2;

  logic [DIR_W-1:0]  dir_s;
  logic [STICKS-1:0] fire_s;
  logic [TRIGS-1:0]  trig_s;
  logic [DIR_W-1:0]  dir_val;
  logic [NIB-1:0]    fire_val;
  logic              wr_dir, rd_dir;

  jp_sync #(.W(DIR_W), .STAGES(SYNC_STAGES)) u_sync_dir (
    .clk(clk), .rst_n(rst_n), .d(dir_in), .q(dir_s));
  jp_sync #(.W(STICKS), .STAGES(SYNC_STAGES)) u_sync_fire (
    .clk(clk), .rst_n(rst_n), .d(fire_in), .q(fire_s));
  jp_sync #(.W(TRIGS), .STAGES(SYNC_STAGES)) u_sync_trig (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s));

  always_comb begin
    wr_dir  = bus_wr && (bus_addr == A_DIR);
    rd_dir  = bus_rd && (bus_addr == A_DIR);
    dir_val = dir_s;
    dir_val[1] = dir_s[1] | trig_s[0];
    dir_val[2] = dir_s[2] | trig_s[1];
    fire_val = {fire_s[3], fire_s[1], fire_s[2], fire_s[0]};
  end

  jp_drive u_drive (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .rd_dir(rd_dir),
    .wdata(bus_wdata[DIR_W-1:0]), .dir_out(dir_out), .dir_oe(dir_oe));

  jp_rdmux u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .dir_val(dir_val), .fire_val(fire_val), .pad_pos(pad_pos),
    .gun_x(gun_x), .gun_y(gun_y), .rdata(bus_rdata));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_oe == '0));
  // R11
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && rd_dir) |=> (dir_oe != '0));
endmodule

// File: tb/test_joyport_regs.sv
`timescale 1ns/1ps
module test_joyport_regs;
  import joyport_pkg::*;

  localparam logic [15:0] MASK = 16'h0F0F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic [15:0] ext, dir_in, dir_out, dir_oe;
  logic [3:0]  fire_in;
  logic [1:0]  trig_in;
  logic [31:0] pad_pos;
  logic [9:0]  gun_x, gun_y;

  int checks = 0;
  int errors = 0;
  bit m_drive;
  logic [15:0] m_out;

  always #5 clk = ~clk;
  assign dir_in = (dir_oe & dir_out) | (~dir_oe & ext);

  joyport_regs i_joyport_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dir_in(dir_in), .dir_out(dir_out), .dir_oe(dir_oe),
    .fire_in(fire_in), .trig_in(trig_in), .pad_pos(pad_pos),
    .gun_x(gun_x), .gun_y(gun_y));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pins_now();
    logic [15:0] oe = m_drive ? MASK : 16'h0;
    return (oe & m_out) | (~oe & ext);
  endfunction

  function automatic logic [15:0] exp_read(logic [2:0] a);
    logic [15:0] v;
    v = 16'h0;
    case (a)
      3'd0: v[3:0] = {fire_in[3], fire_in[1], fire_in[2], fire_in[0]};
      3'd1: begin
        v = pins_now();
        v[1] = v[1] | trig_in[0];
        v[2] = v[2] | trig_in[1];
      end
      3'd2, 3'd3, 3'd4, 3'd5: v[7:0] = pad_pos[(a-3'd2)*8 +: 8];
      3'd6: v[9:0] = gun_x;
      default: v[9:0] = gun_y;
    endcase
    return v;
  endfunction

  task automatic check_pins(string req);
    chk(req, dir_oe, m_drive ? MASK : 16'h0);
    chk(req, dir_out, m_out);
  endtask

  task automatic do_write(logic [2:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    if (a == 3'd1) begin m_drive = 1'b1; m_out = d & MASK; end
  endtask

  task automatic do_read(logic [2:0] a, string req);
    logic [15:0] e;
    repeat (3) @(negedge clk);
    e = exp_read(a);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    if (a == 3'd1) m_drive = 1'b0;
    chk(req, bus_rdata, e);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ext = 16'hA5C3; fire_in = 4'b0110; trig_in = 2'b00;
    pad_pos = 32'h44332211; gun_x = 10'h2AB; gun_y = 10'h155;
    m_drive = 0; m_out = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", dir_oe, 16'h0); chk("R1", dir_out, 16'h0); chk("R1", bus_rdata, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 undriven read
    do_read(3'd1, "R2");
    // R6 fire order
    do_read(3'd0, "R6");
    fire_in = 4'b1001; do_read(3'd0, "R6");
    // R8 / R9 positions
    for (int a = 2; a < 8; a++) do_read(3'(a), a < 6 ? "R8" : "R9");
    // R3 write drive, upper stick bits ignored
    do_write(3'd1, 16'hFFFF); check_pins("R3");
    // R5 other-address write ignored, other-address read keeps drive
    do_write(3'd3, 16'h1234); check_pins("R5");
    do_read(3'd6, "R4"); check_pins("R4");
    repeat (5) @(negedge clk); check_pins("R5");
    // R2 read while driven then R4 release
    do_read(3'd1, "R2"); check_pins("R4");
    chk("R5", dir_out, 16'h0F0F);
    // R7 triggers
    ext = 16'h0000; trig_in = 2'b01; do_read(3'd1, "R7");
    trig_in = 2'b10; do_read(3'd1, "R7");
    trig_in = 2'b00;
    // R10 hold without read
    held = bus_rdata;
    ext = 16'hFFFF; gun_x = 10'h001;
    do_write(3'd1, 16'h0A05);
    repeat (4) @(negedge clk);
    chk("R10", bus_rdata, held);
    // R11 simultaneous write and read of direction
    do_read(3'd1, "R2");
    repeat (3) @(negedge clk);
    bus_addr = 3'd1; bus_wdata = 16'h0306; bus_wr = 1; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    m_drive = 1; m_out = 16'h0306;
    check_pins("R11");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: begin
          do_write(3'($urandom_range(0, 7)), 16'($urandom));
          check_pins("R3");
        end
        1: begin
          ext = 16'($urandom); fire_in = 4'($urandom); trig_in = 2'($urandom);
          pad_pos = $urandom; gun_x = 10'($urandom); gun_y = 10'($urandom);
        end
        default: begin
          logic [2:0] a = 3'($urandom_range(0, 7));
          do_read(a, a == 3'd1 ? "R2" : a == 3'd0 ? "R6" : a < 3'd6 ? "R8" : "R9");
          check_pins("R4");
        end
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule